// File: doc/BRIEF.md
# Deferred Floating-Point Context Save Controller

This block decides, on every exception entry, whether room for floating-point state is reserved on the stack and whether the copy of that state is put off until later. The interrupted context reports whether it holds floating-point state. If it does and deferral is enabled, the block arms a pending-save flag and records a frame address. That address is the stack pointer rounded down to an 8-byte boundary. The first permitted floating-point instruction inside the handler then raises a one-cycle save request to the recorded address and drops the flag. If the handler returns without touching the FPU, the flag is dropped and no copy is made.

The block also holds the access-permission field that gates floating-point instructions, the deferral enable, a default status word and the live status word. On every entry the default status word is copied into the live one. A single write port reaches all four registers. The memory transfer and the arithmetic datapath sit outside this block. Only the request and its address leave it.

All outputs are registered, so each effect appears one clock after the strobe that caused it. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `lazy_fpctx_ctrl`

## Requirements
- R1: After reset, deferral is enabled, the access field is 00, no save is pending, the live status is zero and every output is low or zero.
- R2: An entry arms the pending flag only when deferral is enabled and `ctx_fp_i` is high. The recorded frame address is then `sp_i` with bits 2:0 cleared.
- R3: Bits 2:0 of `frame_addr_o` always read zero, also after a write of register select 3 (frame address). An entry in the same cycle takes precedence over that write.
- R4: `long_frame_o` equals the value of `ctx_fp_i` at the most recent entry.
- R5: One cycle after an entry, the live status equals the default status. An entry takes precedence over a same-cycle write to the live status.
- R6: The access field is write data bits 2:1 of register select 0, and bit 0 of that write is the deferral enable. The field decodes as follows: 00 denies all instructions, 01 permits privileged ones only, 10 is reserved and denies, and 11 permits all. A denied instruction gives a one-cycle `fp_fault_o`, requests no save and leaves the pending flag unchanged.
- R7: A permitted instruction while the flag is pending gives a one-cycle `save_req_o` with `save_addr_o` equal to the recorded address, and it clears the flag. Later instructions request nothing.
- R8: A return while the flag is pending clears the flag and requests no save.
- R9: An entry while a save is still pending keeps both the recorded address and the flag.
- R10: With deferral disabled, an entry from a context with FP state requests a save at once to the aligned `sp_i`, and leaves the flag clear.
- R11: A permitted instruction in the same cycle as a return or an entry saves to the old address first. A same-cycle entry may then arm with a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| sp_i | input | 32 | Stack pointer at the FP area of the frame |
| ctx_fp_i | input | 1 | Interrupted context holds FP state |
| fp_instr_i | input | 1 | FP instruction issued in the handler |
| priv_i | input | 1 | Current execution is privileged |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 control, 1 default status, 2 live status, 3 frame address |
| wr_data_i | input | 32 | Register write data |
| long_frame_o | output | 1 | Extended frame selected at last entry |
| lazy_active_o | output | 1 | Deferred save pending |
| frame_addr_o | output | 32 | Recorded frame address |
| save_req_o | output | 1 | One-cycle save request |
| save_addr_o | output | 32 | Address for the save request |
| fp_fault_o | output | 1 | One-cycle access-denied pulse |
| fp_status_o | output | 32 | Live FP status word |

## Verification
Two functions can land in the same cycle: the first-use save trigger, and exception entry or return. The bench arms a pending save and then raises the FP-instruction strobe together with a return strobe. It expects a save to the old address with the flag cleared. It then repeats the case with a nested entry instead of the return. There the expected result is a save to the old address, a newly recorded aligned address, and the flag still set.

// File: rtl/lazy_fpctx_pkg.sv
package lazy_fpctx_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_PRIV = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_FULL = 2'b11
  } fp_access_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DFLT = 2'd1,
    SEL_STAT = 2'd2,
    SEL_ADDR = 2'd3
  } reg_sel_e;

  localparam int unsigned ALIGN_BITS = 3;
endpackage

// File: rtl/lazy_fpctx_access.sv
module lazy_fpctx_access
  import lazy_fpctx_pkg::*;
(
  input  fp_access_e mode_i,
  input  logic       priv_i,
  output logic       permit_o
);
  always_comb begin
    case (mode_i)
      ACC_FULL: permit_o = 1'b1;
      ACC_PRIV: permit_o = priv_i;
      default:  permit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lazy_fpctx_regs.sv
module lazy_fpctx_regs
  import lazy_fpctx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              lazy_en_o,
  output fp_access_e        access_o,
  output logic [STAT_W-1:0] status_o
);
  logic              lazy_q, lazy_d;
  fp_access_e        acc_q, acc_d;
  logic [STAT_W-1:0] dflt_q, dflt_d, stat_q, stat_d;
  logic              upd;

  assign upd = wr_en_i | entry_i;

  always_comb begin
    lazy_d = lazy_q;
    acc_d  = acc_q;
    dflt_d = dflt_q;
    stat_d = stat_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_CTRL: begin
          lazy_d = wr_data_i[0];
          acc_d  = fp_access_e'(wr_data_i[2:1]);
        end
        SEL_DFLT: dflt_d = wr_data_i[STAT_W-1:0];
        SEL_STAT: stat_d = wr_data_i[STAT_W-1:0];
        default:  ;
      endcase
    end
    if (entry_i) stat_d = dflt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lazy_q <= 1'b1;
      acc_q  <= ACC_NONE;
      dflt_q <= '0;
      stat_q <= '0;
    end else if (upd) begin
      lazy_q <= lazy_d;
      acc_q  <= acc_d;
      dflt_q <= dflt_d;
      stat_q <= stat_d;
    end
  end

  assign lazy_en_o = lazy_q;
  assign access_o  = acc_q;
  assign status_o  = stat_q;

  AST_STATUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> stat_q == $past(dflt_q)); // R5
endmodule

// File: rtl/lazy_fpctx_seq.sv
module lazy_fpctx_seq
  import lazy_fpctx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic              return_i,
  input  logic              fp_instr_i,
  input  logic              permit_i,
  input  logic              ctx_fp_i,
  input  logic              lazy_en_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              addr_wr_i,
  input  logic [ADDR_W-1:0] addr_data_i,
  output logic              active_o,
  output logic              long_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output logic              save_req_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              fault_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'((1 << ALIGN_BITS) - 1));

  logic              active_q, active_d, long_q, long_d;
  logic [ADDR_W-1:0] addr_q, addr_d, sadr_q, sadr_d, sp_al;
  logic              save_q, save_d, fault_q, fault_d;
  logic              fp_go, pending, arm, eager, addr_en;

  assign sp_al   = sp_i & ALIGN_MASK;
  assign fp_go   = fp_instr_i & permit_i & active_q;
  assign pending = active_q & ~(fp_go | return_i);
  assign arm     = entry_i & lazy_en_i & ctx_fp_i & ~pending;
  assign eager   = entry_i & ~lazy_en_i & ctx_fp_i;
  assign addr_en = arm | (eager & ~pending) | (addr_wr_i & ~entry_i);

  always_comb begin
    active_d = arm | pending;
    long_d   = entry_i ? ctx_fp_i : long_q;
    addr_d   = (arm | eager) ? sp_al : (addr_data_i & ALIGN_MASK);
    save_d   = fp_go | eager;
    sadr_d   = fp_go ? addr_q : sp_al;
    fault_d  = fp_instr_i & ~permit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      long_q   <= 1'b0;
      save_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      long_q   <= long_d;
      save_q   <= save_d;
      fault_q  <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sadr_q <= '0;
    else if (save_d) sadr_q <= sadr_d;
  end

  assign active_o     = active_q;
  assign long_o       = long_q;
  assign frame_addr_o = addr_q;
  assign save_req_o   = save_q;
  assign save_addr_o  = sadr_q;
  assign fault_o      = fault_q;

  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(entry_i && lazy_en_i && ctx_fp_i)); // R2
  AST_FIRST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && fp_instr_i && permit_i) |=> (save_q && (!active_q || $past(entry_i)))); // R7
  AST_RETURN_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && return_i && !fp_instr_i && !entry_i) |=> (!active_q && !save_q)); // R8
  AST_NESTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && entry_i && !fp_instr_i && !return_i) |=> (active_q && $stable(addr_q))); // R9
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> $past(fp_instr_i && !permit_i)); // R6
endmodule

// File: rtl/lazy_fpctx_ctrl.sv
module lazy_fpctx_ctrl
  import lazy_fpctx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_entry_i,
  input  logic              exc_return_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              ctx_fp_i,
  input  logic              fp_instr_i,
  input  logic              priv_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              long_frame_o,
  output logic              lazy_active_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output logic              save_req_o,
  output logic [ADDR_W-1:0] save_addr_o,
  output logic              fp_fault_o,
  output logic [STAT_W-1:0] fp_status_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       lazy_en, permit, addr_wr;
  fp_access_e access;
  reg_sel_e   sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel     = reg_sel_e'(wr_sel_i);
  assign addr_wr = wr_en_i & (sel == SEL_ADDR);

  lazy_fpctx_regs #(.DATA_W(ADDR_W), .STAT_W(STAT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .entry_i   (exc_entry_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .lazy_en_o (lazy_en),
    .access_o  (access),
    .status_o  (fp_status_o)
  );

  lazy_fpctx_access u_access (
    .mode_i   (access),
    .priv_i   (priv_i),
    .permit_o (permit)
  );

  lazy_fpctx_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .entry_i      (exc_entry_i),
    .return_i     (exc_return_i),
    .fp_instr_i   (fp_instr_i),
    .permit_i     (permit),
    .ctx_fp_i     (ctx_fp_i),
    .lazy_en_i    (lazy_en),
    .sp_i         (sp_i),
    .addr_wr_i    (addr_wr),
    .addr_data_i  (wr_data_i),
    .active_o     (lazy_active_o),
    .long_o       (long_frame_o),
    .frame_addr_o (frame_addr_o),
    .save_req_o   (save_req_o),
    .save_addr_o  (save_addr_o),
    .fault_o      (fp_fault_o)
  );

  AST_ALIGNED_SAVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    save_req_o |-> save_addr_o[2:0] == 3'b000); // R3
endmodule

// File: tb/lazy_fpctx_ctrl_bench.sv
`timescale 1ns/1ps
module lazy_fpctx_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry = 1'b0, ret = 1'b0, fpi = 1'b0, ctx = 1'b0, priv = 1'b0;
  logic [31:0] sp = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        long_o, act_o, save_o, fault_o;
  logic [31:0] faddr_o, saddr_o, stat_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  lazy_fpctx_ctrl u_lazy_fpctx_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_entry_i(entry), .exc_return_i(ret), .sp_i(sp),
    .ctx_fp_i(ctx), .fp_instr_i(fpi), .priv_i(priv), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .long_frame_o(long_o), .lazy_active_o(act_o),
    .frame_addr_o(faddr_o), .save_req_o(save_o), .save_addr_o(saddr_o),
    .fp_fault_o(fault_o), .fp_status_o(stat_o)
  );

  // entry, ret, fpi, ctx, sp, exp_active, exp_save, exp_long, exp_addr
  localparam logic [70:0] TBL [0:11] = '{
    {4'b1001, 32'h2000_0FF4, 3'b101, 32'h2000_0FF0},
    {4'b0010, 32'h0,         3'b011, 32'h2000_0FF0},
    {4'b0010, 32'h0,         3'b001, 32'h2000_0FF0},
    {4'b0100, 32'h0,         3'b001, 32'h2000_0FF0},
    {4'b1000, 32'h0000_0100, 3'b000, 32'h2000_0FF0},
    {4'b0100, 32'h0,         3'b000, 32'h2000_0FF0},
    {4'b1001, 32'h0000_3007, 3'b101, 32'h0000_3000},
    {4'b0100, 32'h0,         3'b001, 32'h0000_3000},
    {4'b1001, 32'h0000_4000, 3'b101, 32'h0000_4000},
    {4'b1001, 32'h0000_3F00, 3'b101, 32'h0000_4000},
    {4'b0010, 32'h0,         3'b011, 32'h0000_4000},
    {4'b0100, 32'h0,         3'b001, 32'h0000_4000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    entry = 0; ret = 0; fpi = 0; ctx = 0; wr_en = 0; sp = '0;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1 reset state
    chk("R1 active", {31'b0, act_o}, 32'd0);
    chk("R1 save", {31'b0, save_o}, 32'd0);
    chk("R1 fault", {31'b0, fault_o}, 32'd0);
    chk("R1 long", {31'b0, long_o}, 32'd0);
    chk("R1 addr", faddr_o, 32'd0);
    chk("R1 status", stat_o, 32'd0);
    // R1 deferral enabled by default; R6 access 00 denies
    entry = 1; ctx = 1; sp = 32'h0000_0014; priv = 1;
    cyc(); idle();
    chk("R1 lazy default arms", {31'b0, act_o}, 32'd1);
    chk("R2 aligned addr", faddr_o, 32'h0000_0010);
    fpi = 1;
    cyc(); idle();
    chk("R6 deny fault", {31'b0, fault_o}, 32'd1);
    chk("R6 deny no save", {31'b0, save_o}, 32'd0);
    chk("R6 deny keeps flag", {31'b0, act_o}, 32'd1);
    ret = 1;
    cyc(); idle();
    chk("R8 return clears", {31'b0, act_o}, 32'd0);
    chk("R8 return no save", {31'b0, save_o}, 32'd0);
    // R6 privileged only
    wreg(2'd0, 32'b011);
    fpi = 1; priv = 0;
    cyc(); idle();
    chk("R6 priv-only user fault", {31'b0, fault_o}, 32'd1);
    fpi = 1; priv = 1;
    cyc(); idle();
    chk("R6 priv-only priv ok", {31'b0, fault_o}, 32'd0);
    // R6 reserved
    wreg(2'd0, 32'b101);
    fpi = 1;
    cyc(); idle();
    chk("R6 reserved fault", {31'b0, fault_o}, 32'd1);
    // table walk with full access
    wreg(2'd0, 32'b111);
    for (int i = 0; i < 12; i++) begin
      {entry, ret, fpi, ctx} = TBL[i][70:67];
      sp = TBL[i][66:35];
      cyc(); idle();
      chk("R2 active", {31'b0, act_o}, {31'b0, TBL[i][34]});
      chk("R7 save", {31'b0, save_o}, {31'b0, TBL[i][33]});
      chk("R4 long", {31'b0, long_o}, {31'b0, TBL[i][32]});
      chk("R9 addr", faddr_o, TBL[i][31:0]);
      if (TBL[i][33]) chk("R7 save addr", saddr_o, TBL[i][31:0]);
    end
    // R5 status copy with entry winning
    wreg(2'd1, 32'h0000_00A5);
    wreg(2'd2, 32'h0000_0011);
    chk("R5 live write", stat_o, 32'h0000_0011);
    entry = 1; ctx = 0; wr_en = 1; wr_sel = 2'd2; wr_data = 32'h77;
    cyc(); idle();
    chk("R5 copy on entry", stat_o, 32'h0000_00A5);
    ret = 1; cyc(); idle();
    // R3 address write drops low bits
    wreg(2'd3, 32'h1234_567F);
    chk("R3 written addr", faddr_o, 32'h1234_5678);
    // R10 eager save
    wreg(2'd0, 32'b110);
    entry = 1; ctx = 1; sp = 32'h8004_0006;
    cyc(); idle();
    chk("R10 eager save", {31'b0, save_o}, 32'd1);
    chk("R10 eager addr", saddr_o, 32'h8004_0000);
    chk("R10 no flag", {31'b0, act_o}, 32'd0);
    ret = 1; cyc(); idle();
    // R11 instruction and return together
    wreg(2'd0, 32'b111);
    entry = 1; ctx = 1; sp = 32'h0000_0500;
    cyc(); idle();
    fpi = 1; ret = 1;
    cyc(); idle();
    chk("R11 ret+instr save", {31'b0, save_o}, 32'd1);
    chk("R11 ret+instr addr", saddr_o, 32'h0000_0500);
    chk("R11 ret+instr flag", {31'b0, act_o}, 32'd0);
    // R11 instruction and nested entry together
    entry = 1; ctx = 1; sp = 32'h0000_0600;
    cyc(); idle();
    entry = 1; ctx = 1; fpi = 1; sp = 32'h0000_070C;
    cyc(); idle();
    chk("R11 entry+instr save", {31'b0, save_o}, 32'd1);
    chk("R11 entry+instr old addr", saddr_o, 32'h0000_0600);
    chk("R11 entry+instr new addr", faddr_o, 32'h0000_0708);
    chk("R11 entry+instr flag", {31'b0, act_o}, 32'd1);
    ret = 1; cyc(); idle();
    done = 1'b1;
    summary();
  end
endmodule